// File: doc/BRIEF.md
# HDLC Line Coder with Frame Check

This block is the bit-serial coding stage that sits between a framing engine and the line in a synchronous or HDLC serial link. On the transmit side it takes one data bit per valid cycle and drives a line level. The level is either the bit itself (NRZ) or a transition-coded level (NRZI). In HDLC mode it follows the last data bit of a frame directly with a 16-bit or 32-bit frame check sequence. While that sequence is being sent, the block raises a busy flag, and the data source must hold off during that time.

On the receive side it takes one line level per valid cycle and recovers the data bits, undoing NRZI when it is enabled. It runs the same CRC over every bit of the frame, including the received check sequence. At the end of the frame it reports a one-cycle completion pulse and a good/bad flag, which it keeps until the next frame completes. A frame start strobe travels with the first bit of a frame and presets the CRC. A frame end strobe travels with the last bit. Flag sequences, zero-bit stuffing and clock recovery belong to neighbouring blocks.

Top module: `hdlc_line_coder`

## Requirements
- R1: With cfg_nrzi low, line_tx equals the accepted data bit, and line_tx_valid is high in the cycle after each accepted tx_valid cycle. After reset, line_tx_valid, rx_valid, rx_done and tx_fcs_busy are low.
- R2: With cfg_nrzi high, an accepted 1 leaves line_tx unchanged and an accepted 0 inverts it. The line level after reset is high.
- R3: With cfg_hdlc high and cfg_crc32 low, the cycle after a bit accepted with tx_eof starts 16 check bits on line_tx, one per cycle, with no gap and least significant bit first. The check value is the ones-complemented reflected CRC with polynomial 0x1021 and an all-ones preset. tx_fcs_busy is high for exactly those 16 cycles.
- R4: With cfg_hdlc and cfg_crc32 high, the check sequence is 32 bits of the ones-complemented reflected CRC with polynomial 0x04C11DB7 and an all-ones preset. It is sent in the same way, and tx_fcs_busy is high for 32 cycles.
- R5: With cfg_hdlc low, no check bits are appended and tx_fcs_busy stays low. On receive, no rx_done pulse is produced.
- R6: While tx_fcs_busy is high, tx_valid, tx_bit, tx_sof and tx_eof are ignored, and the check sequence on the line is unaffected.
- R7: A bit accepted with tx_sof is the first bit of a new frame: the transmit CRC restarts from all ones, whatever the previous frame left in it.
- R8: The receiver drives rx_valid one cycle after each line_rx_valid cycle. With cfg_nrzi low, rx_bit equals the line level. With cfg_nrzi high, rx_bit is 1 when the level equals the previous received level and 0 when it differs, and the previous level starts high after reset.
- R9: In HDLC mode, rx_done pulses once in the cycle after the frame's last bit appears on rx_bit. At the same time rx_crc_ok becomes 1 exactly when the running CRC equals the residue (0xF0B8 for CRC-16, 0xDEBB20E3 for CRC-32). rx_crc_ok changes only with rx_done.
- R10: A receive frame may start with line_rx_sof in the cycle right after the previous frame's line_rx_eof, and each frame is then judged on its own bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hdlc | input | 1 | 1: HDLC mode with frame check; 0: plain synchronous mode |
| cfg_nrzi | input | 1 | 1: NRZI line code; 0: NRZ |
| cfg_crc32 | input | 1 | 1: 32-bit frame check; 0: 16-bit |
| tx_valid | input | 1 | Transmit data bit present |
| tx_bit | input | 1 | Transmit data bit |
| tx_sof | input | 1 | Marks the first bit of a transmit frame |
| tx_eof | input | 1 | Marks the last data bit of a transmit frame |
| tx_fcs_busy | output | 1 | Check sequence being sent; transmit inputs ignored |
| line_tx_valid | output | 1 | Line level on line_tx is valid |
| line_tx | output | 1 | Coded transmit line level |
| line_rx_valid | input | 1 | Received line level present |
| line_rx | input | 1 | Received line level |
| line_rx_sof | input | 1 | Marks the first received bit of a frame |
| line_rx_eof | input | 1 | Marks the last received bit (last check bit) of a frame |
| rx_valid | output | 1 | Decoded bit on rx_bit is valid |
| rx_bit | output | 1 | Decoded receive bit |
| rx_done | output | 1 | One-cycle pulse: frame check result updated |
| rx_crc_ok | output | 1 | Result of the last completed frame check |

## Verification
Two receive functions can fall in the same cycle. The end-of-frame verdict for one frame is taken in the same cycle that the CRC preset for the next frame happens, because the next frame's first decoded bit arrives alongside the previous frame's completion. The bench provokes this by sending receive frames back to back, with no idle cycle, in the order good CRC-16, corrupted CRC-16, then good CRC-32. Each verdict is judged against a CRC the bench works out separately for that frame alone. On transmit, a new frame with its start strobe is sent in the cycle right after the last check bit of the previous frame. Junk on the inputs during the busy window must leave the expected line sequence intact.

// File: rtl/hlc_pkg.sv
`timescale 1ns/1ps
package hlc_pkg;

    localparam int CRC_MAX_W = 32;
    localparam int CNT_W     = $clog2(CRC_MAX_W + 1);

    typedef enum logic {
        CRC_16 = 1'b0,
        CRC_32 = 1'b1
    } crc_kind_e;

    typedef struct packed {
        logic      hdlc;
        logic      nrzi;
        crc_kind_e kind;
    } coder_cfg_t;

    localparam logic [CRC_MAX_W-1:0] CRC_PRESET = '1;
    localparam logic [15:0] POLY16_REFL   = 16'h8408;
    localparam logic [31:0] POLY32_REFL   = 32'hEDB8_8320;
    localparam logic [15:0] RESIDUE16     = 16'hF0B8;
    localparam logic [31:0] RESIDUE32     = 32'hDEBB_20E3;

    // One reflected CRC step: shift right, fold in the feedback bit.
    function automatic logic [CRC_MAX_W-1:0] crc_step(
        input logic [CRC_MAX_W-1:0] cur,
        input logic                 din,
        input crc_kind_e            kind
    );
        logic fb;
        logic [15:0] s16;
        fb = cur[0] ^ din;
        if (kind == CRC_16) begin
            s16 = (cur[15:0] >> 1) ^ (fb ? POLY16_REFL : 16'h0000);
            return {16'h0000, s16};
        end
        return (cur >> 1) ^ (fb ? POLY32_REFL : 32'h0000_0000);
    endfunction

    function automatic logic [CNT_W-1:0] fcs_len(input crc_kind_e kind);
        return (kind == CRC_16) ? CNT_W'(16) : CNT_W'(32);
    endfunction

    function automatic logic residue_ok(
        input logic [CRC_MAX_W-1:0] cur,
        input crc_kind_e            kind
    );
        if (kind == CRC_16) return cur[15:0] == RESIDUE16;
        return cur == RESIDUE32;
    endfunction

endpackage

// File: rtl/hlc_nrzi_enc.sv
`timescale 1ns/1ps
module hlc_nrzi_enc (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic nrzi,
    output logic out_valid,
    output logic out_level
);
    logic level_nxt;

    always_comb begin
        if (nrzi) level_nxt = in_bit ? out_level : ~out_level;
        else      level_nxt = in_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_level <= 1'b1;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_level <= level_nxt;
        end
    end

    AST_NRZI_ONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nrzi && in_bit) |=> (out_level == $past(out_level))); // R2
    AST_NRZI_ZERO_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nrzi && !in_bit) |=> (out_level != $past(out_level))); // R2
    AST_NRZ_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !nrzi) |=> (out_valid && out_level == $past(in_bit))); // R1
endmodule

// File: rtl/hlc_nrzi_dec.sv
`timescale 1ns/1ps
module hlc_nrzi_dec (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_level,
    input  logic nrzi,
    output logic out_valid,
    output logic out_bit
);
    logic prev_level;
    logic bit_nxt;

    assign bit_nxt = nrzi ? (in_level == prev_level) : in_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_level <= 1'b1;
            out_valid  <= 1'b0;
            out_bit    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bit    <= bit_nxt;
                prev_level <= in_level;
            end
        end
    end

    AST_DEC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8
    AST_DEC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8
endmodule

// File: rtl/hlc_tx_path.sv
`timescale 1ns/1ps
module hlc_tx_path
    import hlc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hdlc,
    input  crc_kind_e kind,
    input  logic      tx_valid,
    input  logic      tx_bit,
    input  logic      tx_sof,
    input  logic      tx_eof,
    output logic      fcs_active,
    output logic      enc_valid,
    output logic      enc_bit
);
    logic [CRC_MAX_W-1:0] crc_q;
    logic [CRC_MAX_W-1:0] crc_base;
    logic [CRC_MAX_W-1:0] crc_nxt;
    logic [CRC_MAX_W-1:0] fcs_sh;
    logic [CNT_W-1:0]     fcs_cnt;
    logic                 accept;

    assign fcs_active = (fcs_cnt != '0);
    assign accept     = tx_valid && !fcs_active;
    assign crc_base   = tx_sof ? CRC_PRESET : crc_q;
    assign crc_nxt    = crc_step(crc_base, tx_bit, kind);
    assign enc_valid  = fcs_active || accept;
    assign enc_bit    = fcs_active ? fcs_sh[0] : tx_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q   <= CRC_PRESET;
            fcs_sh  <= '0;
            fcs_cnt <= '0;
        end else if (fcs_active) begin
            fcs_sh  <= fcs_sh >> 1;
            fcs_cnt <= fcs_cnt - 1'b1;
        end else if (accept) begin
            crc_q <= crc_nxt;
            if (tx_eof && hdlc) begin
                fcs_sh  <= ~crc_nxt;
                fcs_cnt <= fcs_len(kind);
            end
        end
    end

    AST_FCS_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (rst)
        (accept && tx_eof && hdlc) |=> fcs_active); // R3
    AST_SYNC_NO_FCS: assert property (@(posedge clk) disable iff (rst)
        (accept && !hdlc && !fcs_active) |=> !fcs_active); // R5
endmodule

// File: rtl/hlc_rx_path.sv
`timescale 1ns/1ps
module hlc_rx_path
    import hlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  coder_cfg_t cfg,
    input  logic       line_valid,
    input  logic       line_level,
    input  logic       line_sof,
    input  logic       line_eof,
    output logic       bit_valid,
    output logic       bit_out,
    output logic       done,
    output logic       crc_ok
);
    logic                 sof_q;
    logic                 eof_q;
    logic [CRC_MAX_W-1:0] crc_q;
    logic [CRC_MAX_W-1:0] crc_base;
    logic [CRC_MAX_W-1:0] crc_nxt;
    logic                 frame_end;

    hlc_nrzi_dec dec_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (line_valid),
        .in_level  (line_level),
        .nrzi      (cfg.nrzi),
        .out_valid (bit_valid),
        .out_bit   (bit_out)
    );

    assign crc_base  = sof_q ? CRC_PRESET : crc_q;
    assign crc_nxt   = crc_step(crc_base, bit_out, cfg.kind);
    assign frame_end = bit_valid && eof_q && cfg.hdlc;

    always_ff @(posedge clk) begin
        if (rst) begin
            sof_q  <= 1'b0;
            eof_q  <= 1'b0;
            crc_q  <= CRC_PRESET;
            done   <= 1'b0;
            crc_ok <= 1'b0;
        end else begin
            sof_q <= line_valid && line_sof;
            eof_q <= line_valid && line_eof;
            done  <= frame_end;
            if (bit_valid) crc_q <= crc_nxt;
            if (frame_end) crc_ok <= residue_ok(crc_nxt, cfg.kind);
        end
    end

    AST_OK_MOVES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(crc_ok) |-> done); // R9
    AST_SYNC_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && eof_q && !cfg.hdlc) |=> !done); // R5
endmodule

// File: rtl/hdlc_line_coder.sv
`timescale 1ns/1ps
module hdlc_line_coder
    import hlc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_hdlc,
    input  logic cfg_nrzi,
    input  logic cfg_crc32,
    input  logic tx_valid,
    input  logic tx_bit,
    input  logic tx_sof,
    input  logic tx_eof,
    output logic tx_fcs_busy,
    output logic line_tx_valid,
    output logic line_tx,
    input  logic line_rx_valid,
    input  logic line_rx,
    input  logic line_rx_sof,
    input  logic line_rx_eof,
    output logic rx_valid,
    output logic rx_bit,
    output logic rx_done,
    output logic rx_crc_ok
);
    coder_cfg_t cfg;
    logic       enc_valid;
    logic       enc_bit;

    assign cfg.hdlc = cfg_hdlc;
    assign cfg.nrzi = cfg_nrzi;
    assign cfg.kind = cfg_crc32 ? CRC_32 : CRC_16;

    hlc_tx_path tx_i (
        .clk        (clk),
        .rst        (rst),
        .hdlc       (cfg.hdlc),
        .kind       (cfg.kind),
        .tx_valid   (tx_valid),
        .tx_bit     (tx_bit),
        .tx_sof     (tx_sof),
        .tx_eof     (tx_eof),
        .fcs_active (tx_fcs_busy),
        .enc_valid  (enc_valid),
        .enc_bit    (enc_bit)
    );

    hlc_nrzi_enc enc_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (enc_valid),
        .in_bit    (enc_bit),
        .nrzi      (cfg.nrzi),
        .out_valid (line_tx_valid),
        .out_level (line_tx)
    );

    hlc_rx_path rx_i (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .line_valid (line_rx_valid),
        .line_level (line_rx),
        .line_sof   (line_rx_sof),
        .line_eof   (line_rx_eof),
        .bit_valid  (rx_valid),
        .bit_out    (rx_bit),
        .done       (rx_done),
        .crc_ok     (rx_crc_ok)
    );

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (tx_fcs_busy && $past(tx_fcs_busy) && tx_valid) |=> line_tx_valid); // R6
endmodule

// File: tb/hdlc_line_coder_tb_top.sv
`timescale 1ns/1ps
module hdlc_line_coder_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_hdlc = 1'b0, cfg_nrzi = 1'b0, cfg_crc32 = 1'b0;
    logic tx_valid = 1'b0, tx_bit = 1'b0, tx_sof = 1'b0, tx_eof = 1'b0;
    logic line_rx_valid = 1'b0, line_rx = 1'b1, line_rx_sof = 1'b0, line_rx_eof = 1'b0;
    logic tx_fcs_busy, line_tx_valid, line_tx;
    logic rx_valid, rx_bit, rx_done, rx_crc_ok;

    int n_checks = 0;
    int n_fails  = 0;

    logic  exp_tx[$];
    string exp_tx_tag[$];
    logic  exp_rx[$];
    string exp_rx_tag[$];
    logic  exp_res[$];
    string exp_res_tag[$];

    logic tx_lvl = 1'b1;
    logic rx_lvl = 1'b1;

    always #2.5 clk = ~clk;

    hdlc_line_coder dut_i (
        .clk(clk), .rst(rst),
        .cfg_hdlc(cfg_hdlc), .cfg_nrzi(cfg_nrzi), .cfg_crc32(cfg_crc32),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_fcs_busy(tx_fcs_busy), .line_tx_valid(line_tx_valid), .line_tx(line_tx),
        .line_rx_valid(line_rx_valid), .line_rx(line_rx),
        .line_rx_sof(line_rx_sof), .line_rx_eof(line_rx_eof),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_done(rx_done), .rx_crc_ok(rx_crc_ok)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Independent reference: forward (MSB-side) CRC over the same bit stream,
    // complemented; its bits from the top down are the reflected FCS sent LSB first.
    function automatic logic [31:0] ref_crc(input logic bits[$], input bit c32);
        logic [31:0] r;
        logic msb;
        r = c32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        foreach (bits[i]) begin
            msb = c32 ? r[31] : r[15];
            r = r << 1;
            if (msb ^ bits[i]) r = r ^ (c32 ? 32'h04C1_1DB7 : 32'h0000_1021);
            if (!c32) r = r & 32'h0000_FFFF;
        end
        return c32 ? ~r : (~r & 32'h0000_FFFF);
    endfunction

    function automatic logic code_level(input logic cur, input logic b, input logic nz);
        if (nz) return b ? cur : ~cur;
        return b;
    endfunction

    task automatic tx_frame(input string tag, input int n, input logic [63:0] data,
                            input logic hd, input logic c32, input logic nz,
                            input bit junk);
        logic bits[$];
        logic [31:0] f;
        int w;
        int busy_seen;
        cfg_hdlc = hd; cfg_crc32 = c32; cfg_nrzi = nz;
        for (int i = 0; i < n; i++) begin
            tx_valid = 1'b1; tx_bit = data[i];
            tx_sof = (i == 0); tx_eof = (i == n - 1);
            bits.push_back(data[i]);
            tx_lvl = code_level(tx_lvl, data[i], nz);
            exp_tx.push_back(tx_lvl); exp_tx_tag.push_back(tag);
            step();
        end
        tx_valid = 1'b0; tx_sof = 1'b0; tx_eof = 1'b0;
        if (hd) begin
            w = c32 ? 32 : 16;
            f = ref_crc(bits, c32);
            for (int j = w - 1; j >= 0; j--) begin
                tx_lvl = code_level(tx_lvl, f[j], nz);
                exp_tx.push_back(tx_lvl); exp_tx_tag.push_back(tag);
            end
            busy_seen = 0;
            for (int j = 0; j < w; j++) begin
                if (tx_fcs_busy) busy_seen++;
                if (junk) begin
                    tx_valid = 1'b1; tx_bit = j[0]; tx_sof = 1'b1; tx_eof = 1'b1;
                end
                step();
            end
            tx_valid = 1'b0; tx_sof = 1'b0; tx_eof = 1'b0;
            check(tag, "busy cycles", busy_seen, w);
        end
        check(tag, "busy low after frame", tx_fcs_busy, 0);
    endtask

    task automatic rx_frame(input string tag, input int n, input logic [63:0] data,
                            input logic hd, input logic c32, input logic nz,
                            input int flip);
        logic bits[$];
        logic [31:0] f;
        int w;
        cfg_hdlc = hd; cfg_crc32 = c32; cfg_nrzi = nz;
        for (int i = 0; i < n; i++) bits.push_back(data[i]);
        if (hd) begin
            w = c32 ? 32 : 16;
            f = ref_crc(bits, c32);
            for (int j = w - 1; j >= 0; j--) bits.push_back(f[j]);
        end
        if (flip >= 0) bits[flip] = ~bits[flip];
        foreach (bits[i]) begin
            rx_lvl = code_level(rx_lvl, bits[i], nz);
            line_rx_valid = 1'b1; line_rx = rx_lvl;
            line_rx_sof = (i == 0); line_rx_eof = (i == bits.size() - 1);
            exp_rx.push_back(bits[i]); exp_rx_tag.push_back(tag);
            step();
        end
        if (hd) begin
            exp_res.push_back(flip < 0); exp_res_tag.push_back(tag);
        end
    endtask

    task automatic rx_idle(input int cycles);
        line_rx_valid = 1'b0; line_rx_sof = 1'b0; line_rx_eof = 1'b0;
        for (int i = 0; i < cycles; i++) step();
    endtask

    // Scoreboard monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (line_tx_valid) begin
                if (exp_tx.size() == 0) check("R6", "unexpected line_tx_valid", 1, 0);
                else check(exp_tx_tag.pop_front(), "line_tx", line_tx, exp_tx.pop_front());
            end
            if (rx_valid) begin
                if (exp_rx.size() == 0) check("R8", "unexpected rx_valid", 1, 0);
                else check(exp_rx_tag.pop_front(), "rx_bit", rx_bit, exp_rx.pop_front());
            end
            if (rx_done) begin
                if (exp_res.size() == 0) check("R5", "unexpected rx_done", 1, 0);
                else check(exp_res_tag.pop_front(), "rx_crc_ok", rx_crc_ok, exp_res.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) step();
        rst = 1'b0;
        step();
        // Reset state (R1)
        check("R1", "reset line_tx_valid", line_tx_valid, 0);
        check("R1", "reset rx_valid", rx_valid, 0);
        check("R1", "reset rx_done", rx_done, 0);
        check("R1", "reset tx_fcs_busy", tx_fcs_busy, 0);

        // Plain synchronous, NRZ then NRZI (R1, R2, R5, R8)
        tx_frame("R1", 16, 64'hA5C3, 1'b0, 1'b0, 1'b0, 0);
        tx_frame("R2", 16, 64'h3C0F, 1'b0, 1'b0, 1'b1, 0);
        rx_frame("R5", 12, 64'h9E1, 1'b0, 1'b0, 1'b0, -1);
        rx_frame("R8", 16, 64'h0FF0, 1'b0, 1'b0, 1'b1, -1);
        rx_idle(4);

        // HDLC CRC-16 with junk during busy (R3, R6)
        tx_frame("R3", 24, 64'h7E_5A_C1, 1'b1, 1'b0, 1'b0, 0);
        tx_frame("R6", 20, 64'hB_12_34, 1'b1, 1'b0, 1'b1, 1);
        // HDLC CRC-32 NRZI, then a short frame right after with start strobe (R4, R7)
        tx_frame("R4", 40, 64'h12_3456_789A, 1'b1, 1'b1, 1'b1, 0);
        tx_frame("R7", 8, 64'hE7, 1'b1, 1'b1, 1'b1, 0);

        // Receive checks, back to back (R9, R10)
        rx_frame("R9", 24, 64'hC0FFEE, 1'b1, 1'b0, 1'b0, -1);
        rx_frame("R10", 16, 64'hBEEF, 1'b1, 1'b0, 1'b0, 3);
        rx_frame("R10", 32, 64'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, -1);
        rx_idle(3);
        rx_frame("R9", 8, 64'h81, 1'b1, 1'b1, 1'b1, -1);
        rx_frame("R9", 8, 64'h81, 1'b1, 1'b1, 1'b1, 20);
        rx_idle(8);

        check("R3", "tx queue drained", exp_tx.size(), 0);
        check("R8", "rx queue drained", exp_rx.size(), 0);
        check("R9", "result queue drained", exp_res.size(), 0);
        finish_run();
    end

endmodule